// File: doc/BRIEF.md
# Floating-Point Operand Class Decoder

This block inspects one 64-bit floating-point register value and reports which category it belongs to. A precision select picks the format. In double mode the whole word is decoded as a binary64 value. In single mode only the low 32 bits are decoded, as a binary32 value, and the upper half is ignored. The answer is a one-hot class mask of ten bits, zero-extended to 64 bits, so that it can be written straight back to a register file like any other result.

The decoder has no side effects on any floating-point status. The class is found with a fixed order of tests: infinity, then zero, then subnormal, then NaN, and normal if none of these match. The path is purely combinational. A parameter adds a result register at the output, which is present by default, so the result appears one clock after the operand is presented.

Top module: `fp_class_unit`

## Requirements
- R1: The class mask bit positions are: signaling NaN 0, quiet NaN 1, negative infinity 2, negative normal 3, negative subnormal 4, negative zero 5, positive infinity 6, positive normal 7, positive subnormal 8, positive zero 9.
- R2: Bits 63:10 of the result are always zero.
- R3: Exactly one of bits 9:0 is set for every operand pattern in either precision.
- R4: When `dbl_sel` is 1, the value is decoded with sign in bit 63, an 11-bit exponent in bits 62:52 and a 52-bit fraction in bits 51:0.
- R5: When `dbl_sel` is 0, the value is decoded with sign in bit 31, an 8-bit exponent in bits 30:23 and a 23-bit fraction in bits 22:0. Bits 63:32 have no effect on the result.
- R6: An all-ones exponent with a nonzero fraction is a NaN. It is quiet (bit 1) when the top fraction bit is 1 and signaling (bit 0) when that bit is 0. The sign bit never affects a NaN result.
- R7: An all-ones exponent with a zero fraction is an infinity: bit 2 when the sign is 1, and bit 6 when the sign is 0.
- R8: A zero exponent with a zero fraction gives bit 5 or 9. A zero exponent with a nonzero fraction gives bit 4 or 8. Any other exponent gives bit 3 or 7. In each pair the negative class is chosen when the sign is 1.
- R9: With the default output register (`REG_OUT`=1), the result for an operand is visible after the first rising clock edge at which that operand is presented, and not before. An active-low asynchronous reset clears the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbl_sel | input | 1 | 1 selects double precision, 0 selects single precision |
| operand | input | 64 | Register value to classify |
| class_mask | output | 64 | One-hot class mask, zero-extended |

## Verification
The checker assumes that `dbl_sel` and `operand` hold steady around each rising edge, and that every bit is a defined 0 or 1. Given that, the registered result must reflect the values captured at the previous edge. The bench changes inputs only on falling edges and drives only fully specified constants. Each category in both formats is covered, including values whose sign, top fraction bit or upper half are set so as to expose a wrong field choice.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int CLASS_W  = 10;
    localparam int WORD_W   = 64;
    localparam int SP_EXP_W = 8;
    localparam int SP_FRC_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_FRC_W = 52;

    // Category codes equal their bit position in the class mask.
    typedef enum logic [3:0] {
        CAT_SNAN = 4'd0,
        CAT_QNAN = 4'd1,
        CAT_NINF = 4'd2,
        CAT_NNRM = 4'd3,
        CAT_NSUB = 4'd4,
        CAT_NZER = 4'd5,
        CAT_PINF = 4'd6,
        CAT_PNRM = 4'd7,
        CAT_PSUB = 4'd8,
        CAT_PZER = 4'd9
    } fp_cat_e;

    typedef struct packed {
        logic sign;
        logic exp_ones;
        logic exp_zero;
        logic frac_zero;
        logic frac_top;
    } fp_fields_t;

endpackage

// File: rtl/fpc_field_probe.sv
module fpc_field_probe
    import fpc_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int FMT_W = 1 + EXP_W + FRAC_W
) (
    input  logic [FMT_W-1:0] word,
    output fp_fields_t       flds
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = word[FMT_W-2 -: EXP_W];
    assign frac_f = word[FRAC_W-1:0];

    always_comb begin
        flds.sign      = word[FMT_W-1];
        flds.exp_ones  = &exp_f;
        flds.exp_zero  = ~|exp_f;
        flds.frac_zero = ~|frac_f;
        flds.frac_top  = frac_f[FRAC_W-1];
    end

endmodule

// File: rtl/fpc_prio_encode.sv
module fpc_prio_encode
    import fpc_pkg::*;
(
    input  fp_fields_t         flds,
    output logic [CLASS_W-1:0] mask
);

    fp_cat_e cat;

    // Ordered tests: infinity, zero, subnormal, NaN, else normal.
    always_comb begin
        if (flds.exp_ones && flds.frac_zero)
            cat = flds.sign ? CAT_NINF : CAT_PINF;
        else if (flds.exp_zero && flds.frac_zero)
            cat = flds.sign ? CAT_NZER : CAT_PZER;
        else if (flds.exp_zero)
            cat = flds.sign ? CAT_NSUB : CAT_PSUB;
        else if (flds.exp_ones)
            cat = flds.frac_top ? CAT_QNAN : CAT_SNAN;
        else
            cat = flds.sign ? CAT_NNRM : CAT_PNRM;
    end

    always_comb begin
        mask = '0;
        unique case (cat)
            CAT_SNAN: mask[CAT_SNAN] = 1'b1;
            CAT_QNAN: mask[CAT_QNAN] = 1'b1;
            CAT_NINF: mask[CAT_NINF] = 1'b1;
            CAT_NNRM: mask[CAT_NNRM] = 1'b1;
            CAT_NSUB: mask[CAT_NSUB] = 1'b1;
            CAT_NZER: mask[CAT_NZER] = 1'b1;
            CAT_PINF: mask[CAT_PINF] = 1'b1;
            CAT_PNRM: mask[CAT_PNRM] = 1'b1;
            CAT_PSUB: mask[CAT_PSUB] = 1'b1;
            CAT_PZER: mask[CAT_PZER] = 1'b1;
            default:  mask = '0;
        endcase
    end

endmodule

// File: rtl/fpc_out_stage.sv
module fpc_out_stage #(
    parameter int W       = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (REG_OUT) begin : g_reg
            logic [W-1:0] q_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d;
            end
            assign q = q_r;
        end else begin : g_wire
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/fp_class_unit.sv
module fp_class_unit
    import fpc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbl_sel,
    input  logic [WORD_W-1:0] operand,
    output logic [WORD_W-1:0] class_mask
);

    localparam int SP_W = 1 + SP_EXP_W + SP_FRC_W;

    fp_fields_t         sp_flds;
    fp_fields_t         dp_flds;
    fp_fields_t         sel_flds;
    logic [CLASS_W-1:0] cls;
    logic [WORD_W-1:0]  cls_wide;

    fpc_field_probe #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRC_W)) u_sp_probe (
        .word (operand[SP_W-1:0]),
        .flds (sp_flds)
    );

    fpc_field_probe #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRC_W)) u_dp_probe (
        .word (operand),
        .flds (dp_flds)
    );

    assign sel_flds = dbl_sel ? dp_flds : sp_flds;

    fpc_prio_encode u_encode (
        .flds (sel_flds),
        .mask (cls)
    );

    assign cls_wide = {{(WORD_W-CLASS_W){1'b0}}, cls};

    fpc_out_stage #(.W(WORD_W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cls_wide),
        .q     (class_mask)
    );

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        dbl_sel,
    input logic [63:0] operand,
    input logic [63:0] class_mask
);

    logic        primed;
    logic        s_dbl;
    logic [63:0] s_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    generate
        if (REG_OUT) begin : g_cap
            logic        dbl_q;
            logic [63:0] op_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dbl_q <= 1'b0;
                    op_q  <= '0;
                end else begin
                    dbl_q <= dbl_sel;
                    op_q  <= operand;
                end
            end
            assign s_dbl = dbl_q;
            assign s_op  = op_q;
        end else begin : g_live
            assign s_dbl = dbl_sel;
            assign s_op  = operand;
        end
    endgenerate

    logic c_sign, c_eones, c_ezero, c_fzero, c_qbit;
    assign c_sign  = s_dbl ? s_op[63] : s_op[31];
    assign c_eones = s_dbl ? (s_op[62:52] == 11'h7FF) : (s_op[30:23] == 8'hFF);
    assign c_ezero = s_dbl ? (s_op[62:52] == 11'h000) : (s_op[30:23] == 8'h00);
    assign c_fzero = s_dbl ? (s_op[51:0] == 52'd0) : (s_op[22:0] == 23'd0);
    assign c_qbit  = s_dbl ? s_op[51] : s_op[22];

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> $countones(class_mask[9:0]) == 1); // R3

    AST_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> class_mask[63:10] == '0); // R2

    AST_INF_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && c_eones && c_fzero) |-> class_mask == (c_sign ? 64'h4 : 64'h40)); // R7

    AST_NAN_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && c_eones && !c_fzero) |-> class_mask == (c_qbit ? 64'h2 : 64'h1)); // R6

    AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && c_ezero && c_fzero) |-> class_mask == (c_sign ? 64'h20 : 64'h200)); // R8

endmodule

bind fp_class_unit fpc_checker #(.REG_OUT(REG_OUT)) u_fpc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbl_sel    (dbl_sel),
    .operand    (operand),
    .class_mask (class_mask)
);

// File: tb/fp_class_unit_tb_top.sv
module fp_class_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbl_sel = 1'b0;
    logic [63:0] operand = '0;
    logic [63:0] class_mask;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    fp_class_unit #(.REG_OUT(1'b1)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dbl_sel    (dbl_sel),
        .operand    (operand),
        .class_mask (class_mask)
    );

    typedef struct packed {
        logic        dbl;
        logic [63:0] op;
        logic [9:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 64'h0000000000000000, 10'h200, 4'd8},  // R8 +0 single
        '{1'b0, 64'h0000000080000000, 10'h020, 4'd8},  // R8 -0 single
        '{1'b0, 64'h000000007F800000, 10'h040, 4'd7},  // R7 +inf
        '{1'b0, 64'h00000000FF800000, 10'h004, 4'd7},  // R7 -inf
        '{1'b0, 64'h000000007FC00000, 10'h002, 4'd6},  // R6 quiet
        '{1'b0, 64'h00000000FFC00001, 10'h002, 4'd6},  // R6 quiet, sign set
        '{1'b0, 64'h000000007F800001, 10'h001, 4'd6},  // R6 signaling
        '{1'b0, 64'h00000000FFA00000, 10'h001, 4'd6},  // R6 signaling, sign set
        '{1'b0, 64'h000000003F800000, 10'h080, 4'd8},  // R8 +normal
        '{1'b0, 64'h00000000C0000000, 10'h008, 4'd8},  // R8 -normal
        '{1'b0, 64'h0000000000000001, 10'h100, 4'd8},  // R8 +subnormal
        '{1'b0, 64'h00000000807FFFFF, 10'h010, 4'd8},  // R8 -subnormal
        '{1'b0, 64'hFFFFFFFF00000000, 10'h200, 4'd5},  // R5 upper half ignored
        '{1'b0, 64'h123456787F800000, 10'h040, 4'd5},  // R5 upper half ignored
        '{1'b0, 64'h00000000FFFFFFFF, 10'h002, 4'd5},  // R5 low word only
        '{1'b1, 64'h0000000000000000, 10'h200, 4'd4},  // R4 +0 double
        '{1'b1, 64'h8000000000000000, 10'h020, 4'd4},  // R4 -0 double
        '{1'b1, 64'h7FF0000000000000, 10'h040, 4'd7},  // R7 +inf double
        '{1'b1, 64'hFFF0000000000000, 10'h004, 4'd7},  // R7 -inf double
        '{1'b1, 64'h7FF8000000000000, 10'h002, 4'd6},  // R6 quiet double
        '{1'b1, 64'h7FF0000000000001, 10'h001, 4'd6},  // R6 signaling double
        '{1'b1, 64'h3FF0000000000000, 10'h080, 4'd1},  // R1 +normal position
        '{1'b1, 64'hBFF0000000000000, 10'h008, 4'd1},  // R1 -normal position
        '{1'b1, 64'h000FFFFFFFFFFFFF, 10'h100, 4'd4},  // R4 +subnormal double
        '{1'b1, 64'h8000000000000001, 10'h010, 4'd4},  // R4 -subnormal double
        '{1'b1, 64'h000000007FC00000, 10'h100, 4'd4},  // R4 single NaN pattern is double subnormal
        '{1'b1, 64'h7F80000000000000, 10'h080, 4'd4}   // R4 exponent not all ones
    };

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic apply(input logic d, input logic [63:0] op);
        @(negedge clk);
        dbl_sel = d;
        operand = op;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check64("R9 reset clears output", class_mask, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].dbl, VECS[i].op);
            check64($sformatf("R%0d vector %0d", VECS[i].req, i),
                    class_mask, {54'd0, VECS[i].exp});
            check64("R2 upper bits zero", {10'd0, class_mask[63:10]}, 64'd0);
            check64("R3 one class bit", 64'($countones(class_mask[9:0])), 64'd1);
        end

        // R9: result must not change before the capturing edge.
        apply(1'b1, 64'h7FF0000000000000);
        @(negedge clk);
        operand = 64'h8000000000000000;
        #2;
        check64("R9 held before edge", class_mask, 64'h40);
        @(posedge clk);
        @(negedge clk);
        check64("R9 updated after edge", class_mask, 64'h20);

        // R5: toggling only the upper half in single mode leaves result as is.
        apply(1'b0, 64'hAAAAAAAA3F800000);
        apply(1'b0, 64'h555555553F800000);
        check64("R5 upper half no effect", class_mask, 64'h80);

        // R9: asynchronous reset mid-run clears output.
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check64("R9 async reset clears", class_mask, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(1'b0, 64'h00000000FF800000);
        check64("R7 after reset release", class_mask, 64'h4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule